// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors. The first is a table of 2-bit saturating counters indexed by the branch address. The second is a table of 2-bit counters indexed by a global history register, which records the outcomes of the most recent resolved branches. A third table of 2-bit chooser counters decides, entry by entry, which component to trust. The chooser table is indexed by the branch address by default, or by the global history when a parameter selects it.

At fetch the block gives the chosen direction, the component it came from, and both raw component predictions, all combinationally from the current state. The fetch pipeline carries the two component bits forward with the branch. When the branch resolves, the resolution port returns the address, the real outcome and those two carried bits. In the next clock cycle both component counters move towards the outcome and the history register shifts in the outcome. The chooser moves towards whichever component was right, but only when exactly one of the two was right. History is never updated speculatively.

Top module: `tournament_pred`

## Requirements
- R1: After synchronous reset every component counter and every chooser counter reads 2'b10, and the history register is all zeros. A fetch then gives pred_bim=1, pred_glb=1, pred_use_bim=1 and pred_taken=1.
- R2: The address-indexed counter at index res_pc[PC_LSB +: BIM_IDX_W] counts up on a taken resolution and down on a not-taken one. It saturates at 2'b11 and 2'b00. pred_bim is the MSB of the counter at the index of fetch_pc.
- R3: The history-indexed counter selected by the current history value follows the same counting and saturation rule. pred_glb is its MSB.
- R4: On every valid resolution the history register shifts left by one bit, and res_taken enters at bit 0.
- R5: A chooser counter counts up, saturating at 2'b11, when res_bim_pred equals res_taken and res_glb_pred does not.
- R6: A chooser counter counts down, saturating at 2'b00, when res_glb_pred equals res_taken and res_bim_pred does not. It keeps its value when both component bits were right or both were wrong.
- R7: pred_use_bim is the MSB of the selected chooser counter. pred_taken equals pred_bim when pred_use_bim is 1, and pred_glb otherwise.
- R8: With CHO_BY_HIST=0 the chooser is indexed by pc[PC_LSB +: CHO_IDX_W]. With CHO_BY_HIST=1 it is indexed by the history register, at both fetch and resolution.
- R9: While res_valid is 0, no counter and no history bit changes, whatever the other resolution inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Chosen direction (1 = taken) |
| pred_use_bim | output | 1 | 1 when the address-indexed component was chosen |
| pred_bim | output | 1 | Prediction of the address-indexed component |
| pred_glb | output | 1 | Prediction of the history-indexed component |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome |
| res_bim_pred | input | 1 | pred_bim captured at fetch for this branch |
| res_glb_pred | input | 1 | pred_glb captured at fetch for this branch |

## Verification
On every cycle the assertions check three things: the history shift on each resolution, that history and fetch-side predictions stay frozen when no resolution arrives, and that the chosen direction follows the chooser bit. Other behaviour needs multi-step scenarios in the bench. These are the saturation points of both counter kinds, the hysteresis after saturation, and the three-way train/hold decision of the chooser. They also include the fact that a trained history-indexed entry is reached again only through the history, and the difference in chooser aliasing between address and history indexing.

// File: rtl/tp_pkg.sv
package tp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_INIT = 2'b10;

    typedef enum logic [1:0] {
        CH_HOLD = 2'd0,
        CH_UP   = 2'd1,
        CH_DOWN = 2'd2
    } ch_act_e;

    typedef struct packed {
        logic taken;
        logic use_bim;
        logic bim;
        logic glb;
    } pred_t;

    function automatic ctr2_t sat_step(input ctr2_t c, input logic up);
        ctr2_t n;
        if (up) n = (c == 2'b11) ? c : c + 2'd1;
        else    n = (c == 2'b00) ? c : c - 2'd1;
        return n;
    endfunction

    function automatic ch_act_e chooser_act(input logic taken, input logic bim, input logic glb);
        logic bim_ok;
        logic glb_ok;
        bim_ok = (bim == taken);
        glb_ok = (glb == taken);
        if (bim_ok && !glb_ok)      return CH_UP;
        else if (!bim_ok && glb_ok) return CH_DOWN;
        else                        return CH_HOLD;
    endfunction

endpackage

// File: rtl/sat_ctr_table.sv
module sat_ctr_table
    import tp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr2_t            rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    ctr2_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= CTR_INIT;
        end else if (wr_en) begin
            cells[wr_idx] <= sat_step(cells[wr_idx], wr_up);
        end
    end

    assign rd_ctr = cells[rd_idx];

endmodule

// File: rtl/hist_reg.sv
module hist_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] hist
);
    always_ff @(posedge clk) begin
        if (rst)           hist <= '0;
        else if (shift_en) hist <= {hist[W-2:0], bit_in};
    end
endmodule

// File: rtl/tournament_pred.sv
module tournament_pred
    import tp_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int PC_LSB      = 2,
    parameter int BIM_IDX_W   = 10,
    parameter int GHR_W       = 12,
    parameter int CHO_IDX_W   = 10,
    parameter bit CHO_BY_HIST = 1'b0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic            pred_use_bim,
    output logic            pred_bim,
    output logic            pred_glb,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_bim_pred,
    input  logic            res_glb_pred
);
    localparam int CHO_W = CHO_BY_HIST ? GHR_W : CHO_IDX_W;

    logic [GHR_W-1:0]     hist;
    logic [BIM_IDX_W-1:0] bim_rd_idx, bim_wr_idx;
    logic [CHO_W-1:0]     cho_rd_idx, cho_wr_idx;
    ctr2_t                bim_ctr, glb_ctr, cho_ctr;
    ch_act_e              ch_act;
    pred_t                pred;
    wire                  unused_pc = ^{fetch_pc, res_pc};

    assign bim_rd_idx = fetch_pc[PC_LSB +: BIM_IDX_W];
    assign bim_wr_idx = res_pc[PC_LSB +: BIM_IDX_W];

    generate
        if (CHO_BY_HIST) begin : g_cho_hist
            assign cho_rd_idx = hist;
            assign cho_wr_idx = hist;
        end else begin : g_cho_addr
            assign cho_rd_idx = fetch_pc[PC_LSB +: CHO_W];
            assign cho_wr_idx = res_pc[PC_LSB +: CHO_W];
        end
    endgenerate

    assign ch_act = chooser_act(res_taken, res_bim_pred, res_glb_pred);

    hist_reg #(.W(GHR_W)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .shift_en (res_valid),
        .bit_in   (res_taken),
        .hist     (hist)
    );

    sat_ctr_table #(.IDX_W(BIM_IDX_W)) u_bim (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (bim_rd_idx),
        .rd_ctr (bim_ctr),
        .wr_en  (res_valid),
        .wr_idx (bim_wr_idx),
        .wr_up  (res_taken)
    );

    sat_ctr_table #(.IDX_W(GHR_W)) u_glb (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (hist),
        .rd_ctr (glb_ctr),
        .wr_en  (res_valid),
        .wr_idx (hist),
        .wr_up  (res_taken)
    );

    sat_ctr_table #(.IDX_W(CHO_W)) u_cho (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (cho_rd_idx),
        .rd_ctr (cho_ctr),
        .wr_en  (res_valid && (ch_act != CH_HOLD)),
        .wr_idx (cho_wr_idx),
        .wr_up  (ch_act == CH_UP)
    );

    always_comb begin
        pred.bim     = bim_ctr[1];
        pred.glb     = glb_ctr[1];
        pred.use_bim = cho_ctr[1];
        pred.taken   = pred.use_bim ? pred.bim : pred.glb;
    end

    assign pred_taken   = pred.taken;
    assign pred_use_bim = pred.use_bim;
    assign pred_bim     = pred.bim;
    assign pred_glb     = pred.glb;

endmodule

// File: rtl/tournament_pred_chk.sv
module tournament_pred_chk #(
    parameter int PC_W  = 32,
    parameter int GHR_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic [PC_W-1:0]  fetch_pc,
    input logic             res_valid,
    input logic             res_taken,
    input logic [GHR_W-1:0] hist,
    input logic             pred_taken,
    input logic             pred_use_bim,
    input logic             pred_bim,
    input logic             pred_glb
);
    a_r1_hist_cleared: assert property (@(posedge clk) rst |=> (hist == '0));

    a_r4_hist_shift: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> (hist == {$past(hist[GHR_W-2:0]), $past(res_taken)}));

    a_r9_hist_hold: assert property (@(posedge clk) disable iff (rst)
        !res_valid |=> $stable(hist));

    a_r9_pred_steady: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(res_valid) && $stable(fetch_pc))
        |-> ($stable(pred_bim) && $stable(pred_glb) && $stable(pred_use_bim)));

    a_r7_pick: assert property (@(posedge clk) disable iff (rst)
        pred_taken == (pred_use_bim ? pred_bim : pred_glb));
endmodule

bind tournament_pred tournament_pred_chk #(.PC_W(PC_W), .GHR_W(GHR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fetch_pc     (fetch_pc),
    .res_valid    (res_valid),
    .res_taken    (res_taken),
    .hist         (hist),
    .pred_taken   (pred_taken),
    .pred_use_bim (pred_use_bim),
    .pred_bim     (pred_bim),
    .pred_glb     (pred_glb)
);

// File: tb/tb_tournament_pred.sv
module tb_tournament_pred;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic        res_bim_pred = 1'b0;
    logic        res_glb_pred = 1'b0;
    logic        p_taken, p_use, p_bim, p_glb;
    logic        h_taken, h_use, h_bim, h_glb;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    localparam logic [31:0] PC_A = 32'h0000_0100;
    localparam logic [31:0] PC_B = 32'h0000_0204;

    // bits: {outcome, exp_bim, exp_glb, exp_use_bim, exp_taken}
    localparam logic [4:0] VEC [13] = '{
        5'b01111, 5'b00010, 5'b10010, 5'b10110, 5'b01101,
        5'b00101, 5'b10110, 5'b10101, 5'b11101, 5'b01101,
        5'b01101, 5'b10101, 5'b01101
    };

    always #5 clk = ~clk;

    tournament_pred dut (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_taken(p_taken), .pred_use_bim(p_use), .pred_bim(p_bim), .pred_glb(p_glb),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_bim_pred(res_bim_pred), .res_glb_pred(res_glb_pred)
    );

    tournament_pred #(.CHO_BY_HIST(1'b1)) dut_h (
        .clk(clk), .rst(rst), .fetch_pc(fetch_pc),
        .pred_taken(h_taken), .pred_use_bim(h_use), .pred_bim(h_bim), .pred_glb(h_glb),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_bim_pred(res_bim_pred), .res_glb_pred(res_glb_pred)
    );

    task automatic chk(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        res_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic fetch(input logic [31:0] pc);
        @(negedge clk);
        fetch_pc = pc;
        #1;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic t, input logic b, input logic g);
        @(negedge clk);
        res_pc = pc;
        res_taken = t;
        res_bim_pred = b;
        res_glb_pred = g;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    initial begin
        do_reset();

        // R1: reset state in both variants
        fetch(PC_A);
        chk(p_bim, 1'b1, "R1 bim after reset");
        chk(p_glb, 1'b1, "R1 glb after reset");
        chk(p_use, 1'b1, "R1 chooser after reset");
        chk(p_taken, 1'b1, "R1 taken after reset");
        chk(h_use, 1'b1, "R1 hist-chooser after reset");

        // R2 R3 R4 R5 R6 R7: one branch walked through the vector table
        for (int i = 0; i < 13; i++) begin
            logic b, g;
            fetch(PC_A);
            chk(p_bim, VEC[i][3], $sformatf("R2 bim step %0d", i));
            chk(p_glb, VEC[i][2], $sformatf("R3 R4 glb step %0d", i));
            chk(p_use, VEC[i][1], $sformatf("R5 R6 chooser step %0d", i));
            chk(p_taken, VEC[i][0], $sformatf("R7 taken step %0d", i));
            b = p_bim;
            g = p_glb;
            resolve(PC_A, VEC[i][4], b, g);
        end
        fetch(PC_A);
        chk(p_bim, 1'b0, "R2 bim final");
        chk(p_glb, 1'b1, "R3 glb final");
        chk(p_use, 1'b0, "R6 chooser floor");
        chk(p_taken, 1'b1, "R7 taken final");

        // R2: saturation at 11 and hysteresis
        do_reset();
        for (int i = 0; i < 3; i++) resolve(PC_A, 1'b1, 1'b1, 1'b1);
        resolve(PC_A, 1'b0, 1'b1, 1'b1);
        fetch(PC_A);
        chk(p_bim, 1'b1, "R2 bim saturated then one NT");
        resolve(PC_A, 1'b0, 1'b1, 1'b1);
        fetch(PC_A);
        chk(p_bim, 1'b0, "R2 bim after second NT");

        // R9: invalid resolutions ignored
        do_reset();
        resolve(PC_A, 1'b0, 1'b1, 1'b1);
        resolve(PC_A, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        res_pc = PC_A;
        res_taken = 1'b1;
        res_bim_pred = 1'b0;
        res_glb_pred = 1'b1;
        res_valid = 1'b0;
        repeat (3) @(negedge clk);
        fetch(PC_A);
        chk(p_bim, 1'b0, "R9 bim unchanged");
        chk(p_glb, 1'b0, "R9 glb and history unchanged");
        chk(p_use, 1'b1, "R9 chooser unchanged");

        // R5 R6: chooser saturation and hold
        do_reset();
        resolve(PC_A, 1'b1, 1'b1, 1'b0);
        resolve(PC_A, 1'b1, 1'b1, 1'b0);
        resolve(PC_A, 1'b1, 1'b0, 1'b1);
        fetch(PC_A);
        chk(p_use, 1'b1, "R5 chooser saturated at 11");
        resolve(PC_A, 1'b1, 1'b0, 1'b1);
        fetch(PC_A);
        chk(p_use, 1'b0, "R6 chooser decrement");
        resolve(PC_A, 1'b1, 1'b0, 1'b0);
        resolve(PC_A, 1'b1, 1'b1, 1'b1);
        fetch(PC_A);
        chk(p_use, 1'b0, "R6 chooser hold");
        resolve(PC_A, 1'b1, 1'b1, 1'b0);
        fetch(PC_A);
        chk(p_use, 1'b1, "R5 chooser increment");

        // R8: chooser index selection
        do_reset();
        resolve(PC_A, 1'b0, 1'b1, 1'b0);
        fetch(PC_B);
        chk(p_use, 1'b1, "R8 address-indexed chooser other pc");
        chk(h_use, 1'b0, "R8 history-indexed chooser shared entry");
        fetch(PC_A);
        chk(p_use, 1'b0, "R8 address-indexed chooser trained pc");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule